// File: doc/BRIEF.md
# Row Write Collector and Timed Program Sequencer

This block sits behind the serial protocol engine of a byte-addressed non-volatile memory. When a write transaction begins, the engine hands over a 13-bit start address and the level of the write-inhibit input. Each data byte that the engine accepts is then stored into a row buffer of 32 byte slots. Every slot has its own valid flag. The buffer covers one row, meaning the addresses that share bits 12..5. Only the 5-bit column part of the address advances from one byte to the next. Once it passes the last column it comes back to column 0 of the same row, so later bytes overwrite earlier ones.

The engine also reports bit-slot boundaries and the STOP conditions it decodes. A STOP commits the buffer only when it lands in the slot directly after the acknowledge of a stored data byte. Any other STOP throws the buffer away. At commit the block walks all 32 columns in ascending order, one per clock. For each column with its valid flag set, it drives a write into a synchronous single-port array. It then counts a programmable number of clocks. Busy is held for the whole walk and the count, so the protocol engine can refuse to acknowledge while the cycle runs. Every input is ignored while busy is high.

Top module: `pgbuf_prog_ctrl`

## Requirements
- R1: After reset, busy and mem_we are low.
- R2: When byte_stb is pulsed and not refused, byte_data is stored at the current column. The column then advances by one modulo 32, and the row bits do not change. A write past column 31 lands in column 0 and replaces the byte stored there.
- R3: A stop_stb commits only when it arrives after a stored byte with no bit_tick in between. A stop_stb at any other time clears the buffer, and busy stays low.
- R4: If wc_level is high when txn_start is pulsed, every byte of that transaction is refused and its STOP starts no program cycle.
- R5: During commit, the block writes only columns whose valid flag is set, one per clock and in ascending column order. mem_addr is {row, column} and mem_wdata is the last byte stored in that column.
- R6: busy rises in the cycle after the committing stop_stb and stays high for exactly 32 + PROG_CYCLES cycles.
- R7: While busy is high, txn_start, byte_stb, bit_tick and stop_stb have no effect. The cycle in progress and all later commits look as if those pulses had never arrived.
- R8: All valid flags are cleared on txn_start and at the end of a program cycle, so a later commit writes only the columns filled by its own transaction.
- R9: mem_we is high only while busy is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| txn_start | input | 1 | Pulse: a new write transaction begins |
| start_addr | input | 13 | Start address, taken on txn_start |
| wc_level | input | 1 | Write-inhibit level, taken on txn_start |
| byte_stb | input | 1 | Pulse: a data byte was received and acknowledged |
| byte_data | input | 8 | Data byte that goes with byte_stb |
| bit_tick | input | 1 | Pulse: a new bit slot started on the bus |
| stop_stb | input | 1 | Pulse: a STOP condition was decoded |
| busy | output | 1 | Commit walk or timed program cycle in progress |
| mem_we | output | 1 | Array write enable |
| mem_addr | output | 13 | Array write address |
| mem_wdata | output | 8 | Array write data |

## Verification
The assertions assume the protocol engine sends single-cycle pulses and never raises two of txn_start, byte_stb, bit_tick and stop_stb in the same cycle. The bench drives one pulse per cycle from tasks, so it stays inside that assumption. It also exercises the cases the assertions depend on: a STOP inside the slot after an acknowledge, a STOP after a slot boundary, a protected transaction, and pulses sent while busy is high. A behavioural row model built from queues predicts busy, mem_we, mem_addr and mem_wdata, and the bench compares them with the design on every clock.

// File: rtl/pgbuf_pkg.sv
package pgbuf_pkg;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_SCAN = 2'd1,
    PH_WAIT = 2'd2
  } phase_e;

  // next column inside a row of 2**col_w slots
  function automatic int unsigned wrap_col(input int unsigned col, input int unsigned col_w);
    return (col + 1) & ((32'd1 << col_w) - 1);
  endfunction

  // last scan index of a row
  function automatic int unsigned last_col(input int unsigned col_w);
    return (32'd1 << col_w) - 1;
  endfunction

endpackage

// File: rtl/pgbuf_store.sv
module pgbuf_store #(
  parameter int COL_W  = 5,
  parameter int ROW_W  = 8,
  parameter int DATA_W = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    load,
  input  logic [ROW_W+COL_W-1:0]  load_addr,
  input  logic                    wr_en,
  input  logic [DATA_W-1:0]       wr_data,
  input  logic                    clear,
  input  logic [COL_W-1:0]        rd_idx,
  output logic [ROW_W-1:0]        row,
  output logic [COL_W-1:0]        col,
  output logic                    rd_valid,
  output logic [DATA_W-1:0]       rd_data
);
  localparam int DEPTH = 1 << COL_W;

  logic [DATA_W-1:0] dat_w [DEPTH];
  logic [DEPTH-1:0]  vld_w;
  logic [ROW_W-1:0]  row_q;
  logic [COL_W-1:0]  col_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      row_q <= '0;
      col_q <= '0;
    end else if (load) begin
      row_q <= load_addr[ROW_W+COL_W-1:COL_W];
      col_q <= load_addr[COL_W-1:0];
    end else if (wr_en) begin
      col_q <= COL_W'(pgbuf_pkg::wrap_col(32'(col_q), COL_W));
    end
  end

  generate
    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
      logic [DATA_W-1:0] d_q;
      logic              v_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          d_q <= '1;
          v_q <= 1'b0;
        end else if (load || clear) begin
          v_q <= 1'b0;
        end else if (wr_en && col_q == COL_W'(i)) begin
          d_q <= wr_data;
          v_q <= 1'b1;
        end
      end
      assign dat_w[i] = d_q;
      assign vld_w[i] = v_q;
    end
  endgenerate

  assign row      = row_q;
  assign col      = col_q;
  assign rd_valid = vld_w[rd_idx];
  assign rd_data  = dat_w[rd_idx];
endmodule

// File: rtl/pgbuf_slot_track.sv
module pgbuf_slot_track (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic txn_start,
  input  logic wc_level,
  input  logic byte_stb,
  input  logic bit_tick,
  input  logic stop_stb,
  output logic armed,
  output logic prot,
  output logic byte_ok,
  output logic commit_req,
  output logic discard
);
  logic armed_q, prot_q;

  assign byte_ok    = en && byte_stb && !txn_start && !stop_stb && !prot_q;
  assign commit_req = en && stop_stb && !txn_start && armed_q && !prot_q;
  assign discard    = en && stop_stb && !txn_start && !commit_req;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      prot_q  <= 1'b0;
    end else if (en) begin
      if (txn_start) begin
        prot_q  <= wc_level;
        armed_q <= 1'b0;
      end else if (stop_stb) begin
        armed_q <= 1'b0;
      end else if (byte_ok) begin
        armed_q <= 1'b1;
      end else if (bit_tick) begin
        armed_q <= 1'b0;
      end
    end
  end

  assign armed = armed_q;
  assign prot  = prot_q;
endmodule

// File: rtl/pgbuf_seq.sv
module pgbuf_seq #(
  parameter int COL_W       = 5,
  parameter int PROG_CYCLES = 2000000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             commit_req,
  output pgbuf_pkg::phase_e phase,
  output logic [COL_W-1:0] scan_idx,
  output logic             cycle_done
);
  import pgbuf_pkg::*;
  localparam int TMR_W = $clog2(PROG_CYCLES + 1);
  localparam logic [COL_W-1:0] LAST = COL_W'(last_col(COL_W));

  phase_e           ph_q;
  logic [COL_W-1:0] idx_q;
  logic [TMR_W-1:0] tmr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q  <= PH_IDLE;
      idx_q <= '0;
      tmr_q <= '0;
    end else begin
      unique case (ph_q)
        PH_IDLE: if (commit_req) begin
          ph_q  <= PH_SCAN;
          idx_q <= '0;
        end
        PH_SCAN: if (idx_q == LAST) begin
          ph_q  <= PH_WAIT;
          tmr_q <= TMR_W'(PROG_CYCLES - 1);
        end else begin
          idx_q <= idx_q + 1'b1;
        end
        PH_WAIT: if (tmr_q == '0) ph_q <= PH_IDLE;
                 else tmr_q <= tmr_q - 1'b1;
        default: ph_q <= PH_IDLE;
      endcase
    end
  end

  assign phase      = ph_q;
  assign scan_idx   = idx_q;
  assign cycle_done = (ph_q == PH_WAIT) && (tmr_q == '0);
endmodule

// File: rtl/pgbuf_prog_ctrl.sv
module pgbuf_prog_ctrl #(
  parameter int ADDR_W      = 13,
  parameter int COL_W       = 5,
  parameter int DATA_W      = 8,
  parameter int PROG_CYCLES = 2000000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              txn_start,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic              wc_level,
  input  logic              byte_stb,
  input  logic [DATA_W-1:0] byte_data,
  input  logic              bit_tick,
  input  logic              stop_stb,
  output logic              busy,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata
);
  import pgbuf_pkg::*;
  localparam int ROW_W = ADDR_W - COL_W;

  phase_e           phase_w;
  logic [COL_W-1:0] scan_idx_w;
  logic             cycle_done_w;
  logic             armed_w, prot_w, byte_ok_w, commit_w, discard_w;
  logic [ROW_W-1:0] row_w;
  logic [COL_W-1:0] col_w;
  logic             rd_valid_w;
  logic [DATA_W-1:0] rd_data_w;
  logic             idle_w;

  assign idle_w = (phase_w == PH_IDLE);

  pgbuf_slot_track u_track (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (idle_w),
    .txn_start (txn_start),
    .wc_level  (wc_level),
    .byte_stb  (byte_stb),
    .bit_tick  (bit_tick),
    .stop_stb  (stop_stb),
    .armed     (armed_w),
    .prot      (prot_w),
    .byte_ok   (byte_ok_w),
    .commit_req(commit_w),
    .discard   (discard_w)
  );

  pgbuf_store #(.COL_W(COL_W), .ROW_W(ROW_W), .DATA_W(DATA_W)) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (idle_w && txn_start),
    .load_addr(start_addr),
    .wr_en    (byte_ok_w),
    .wr_data  (byte_data),
    .clear    (discard_w || cycle_done_w),
    .rd_idx   (scan_idx_w),
    .row      (row_w),
    .col      (col_w),
    .rd_valid (rd_valid_w),
    .rd_data  (rd_data_w)
  );

  pgbuf_seq #(.COL_W(COL_W), .PROG_CYCLES(PROG_CYCLES)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .commit_req(commit_w),
    .phase     (phase_w),
    .scan_idx  (scan_idx_w),
    .cycle_done(cycle_done_w)
  );

  assign busy      = !idle_w;
  assign mem_we    = (phase_w == PH_SCAN) && rd_valid_w;
  assign mem_addr  = {row_w, scan_idx_w};
  assign mem_wdata = rd_data_w;
endmodule

// File: rtl/pgbuf_chk.sv
module pgbuf_chk #(
  parameter int ADDR_W = 13,
  parameter int COL_W  = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              stop_stb,
  input logic              busy,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              armed_w,
  input logic              prot_w
);
  // R9
  we_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> busy);

  // R6
  busy_from_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(stop_stb));

  // R3
  stray_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && stop_stb && !armed_w) |=> !busy);

  // R4
  protected_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && stop_stb && prot_w) |=> !busy);

  // R5
  col_ascend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && $past(mem_we) && $past(busy)) |->
      (mem_addr[COL_W-1:0] > $past(mem_addr[COL_W-1:0])));

  // R7
  row_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(mem_addr[ADDR_W-1:COL_W]));
endmodule

bind pgbuf_prog_ctrl pgbuf_chk #(.ADDR_W(ADDR_W), .COL_W(COL_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .stop_stb(stop_stb),
  .busy    (busy),
  .mem_we  (mem_we),
  .mem_addr(mem_addr),
  .armed_w (armed_w),
  .prot_w  (prot_w)
);

// File: tb/pgbuf_prog_ctrl_tb_top.sv
`timescale 1ns/1ps
module pgbuf_prog_ctrl_tb_top;
  localparam int PC = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic txn_start = 0, wc_level = 0, byte_stb = 0, bit_tick = 0, stop_stb = 0;
  logic [12:0] start_addr = '0;
  logic [7:0]  byte_data = '0;
  logic busy, mem_we;
  logic [12:0] mem_addr;
  logic [7:0]  mem_wdata;

  always #2.5 clk = ~clk;

  pgbuf_prog_ctrl #(.PROG_CYCLES(PC)) dut_i (
    .clk(clk), .rst_n(rst_n), .txn_start(txn_start), .start_addr(start_addr),
    .wc_level(wc_level), .byte_stb(byte_stb), .byte_data(byte_data),
    .bit_tick(bit_tick), .stop_stb(stop_stb), .busy(busy), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata));

  int checks = 0, fails = 0, cyc = 0, n_writes = 0;
  string tag = "R1";

  // behavioural row model
  int   out_q[$];
  int   cur = 0;
  bit   e_busy = 0;
  int   m_row = 0, m_col = 0;
  bit   m_prot = 0, m_armed = 0;
  bit   m_vld[32];
  int   m_dat[32];

  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      out_q.delete(); e_busy = 0; cur = 0; m_armed = 0; m_prot = 0;
      foreach (m_vld[k]) m_vld[k] = 0;
    end else if (e_busy) begin
      if (out_q.size() > 0) cur = out_q.pop_front();
      else begin
        e_busy = 0; cur = 0;
        foreach (m_vld[k]) m_vld[k] = 0;
      end
    end else if (txn_start) begin
      m_row = start_addr / 32; m_col = start_addr % 32;
      m_prot = wc_level; m_armed = 0;
      foreach (m_vld[k]) m_vld[k] = 0;
    end else if (stop_stb) begin
      if (m_armed && !m_prot) begin
        for (int c = 0; c < 32; c++)
          out_q.push_back((int'(m_vld[c]) << 21) | ((m_row * 32 + c) << 8) | m_dat[c]);
        for (int w = 0; w < PC; w++) out_q.push_back(0);
        cur = out_q.pop_front(); e_busy = 1;
      end else begin
        foreach (m_vld[k]) m_vld[k] = 0;
      end
      m_armed = 0;
    end else if (byte_stb && !m_prot) begin
      m_dat[m_col] = byte_data; m_vld[m_col] = 1;
      m_col = (m_col + 1) % 32; m_armed = 1;
    end else if (bit_tick) begin
      m_armed = 0;
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      bit e_we;
      e_we = cur[21];
      checks++;
      if (busy !== e_busy) begin
        fails++; $display("FAIL %s/R6 busy=%0b expected %0b @%0d", tag, busy, e_busy, cyc);
      end else if (mem_we !== e_we) begin
        fails++; $display("FAIL %s/R5 mem_we=%0b expected %0b @%0d", tag, mem_we, e_we, cyc);
      end else if (e_we && mem_addr !== 13'(cur >> 8)) begin
        fails++; $display("FAIL %s/R5 mem_addr=%h expected %h", tag, mem_addr, 13'(cur >> 8));
      end else if (e_we && mem_wdata !== 8'(cur)) begin
        fails++; $display("FAIL %s/R2 mem_wdata=%h expected %h", tag, mem_wdata, 8'(cur));
      end else if (mem_we && !busy) begin
        fails++; $display("FAIL R9 mem_we=1 expected 0 while idle");
      end
      if (mem_we) n_writes++;
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask
  task automatic pulse_txn(input logic [12:0] a, input logic wc);
    @(negedge clk); txn_start = 1; start_addr = a; wc_level = wc;
    @(negedge clk); txn_start = 0; wc_level = 0;
  endtask
  task automatic pulse_byte(input logic [7:0] d);
    @(negedge clk); bit_tick = 1; @(negedge clk); bit_tick = 0;
    byte_stb = 1; byte_data = d; @(negedge clk); byte_stb = 0;
  endtask
  task automatic pulse_stop();
    @(negedge clk); stop_stb = 1; @(negedge clk); stop_stb = 0;
  endtask
  task automatic pulse_tick();
    @(negedge clk); bit_tick = 1; @(negedge clk); bit_tick = 0;
  endtask
  task automatic expect_writes(input string r, input int n);
    checks++;
    if (n_writes != n) begin
      fails++; $display("FAIL %s writes=%0d expected %0d", r, n_writes, n);
    end
    n_writes = 0;
  endtask

  initial begin : watchdog
    wait (cyc > 150000);
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    tick(3);
    checks++;
    if (busy !== 1'b0 || mem_we !== 1'b0) begin
      fails++; $display("FAIL R1 busy=%0b mem_we=%0b expected 0 0", busy, mem_we);
    end
    rst_n = 1; tick(2);

    tag = "R2"; n_writes = 0;
    pulse_txn(13'h0123, 0); pulse_byte(8'h5A); pulse_stop(); tick(40 + PC);
    expect_writes("R5", 1);

    pulse_txn(13'h1F3E, 0);
    pulse_byte(8'h11); pulse_byte(8'h22); pulse_byte(8'h33); pulse_byte(8'h44);
    pulse_stop(); tick(40 + PC);
    expect_writes("R2", 4);

    pulse_txn(13'h0040, 0);
    for (int i = 0; i < 34; i++) pulse_byte(8'(8'hA0 + i));
    pulse_stop(); tick(40 + PC);
    expect_writes("R2", 32);

    tag = "R3";
    pulse_txn(13'h0200, 0); pulse_byte(8'h77); pulse_tick(); pulse_stop(); tick(10);
    expect_writes("R3", 0);
    pulse_stop(); tick(5);

    tag = "R4";
    pulse_txn(13'h0300, 1); pulse_byte(8'h99); pulse_byte(8'h98); pulse_stop(); tick(10);
    expect_writes("R4", 0);

    tag = "R7";
    pulse_txn(13'h0400, 0); pulse_byte(8'h01); pulse_stop();
    pulse_txn(13'h0800, 0); pulse_byte(8'hEE); pulse_byte(8'hEF); pulse_stop();
    tick(40 + PC);
    expect_writes("R7", 1);

    tag = "R8";
    pulse_txn(13'h0415, 0); pulse_byte(8'hC3); pulse_stop(); tick(40 + PC);
    expect_writes("R8", 1);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule